// File: doc/BRIEF.md
# Two-Operand Register Processor Core

This block is a compact 32-bit processor core. Each cycle it presents a program counter on its fetch port and takes back a 16-bit instruction word in the same cycle. The word holds a 6-bit operation code and two 5-bit register indices. The core has thirty-two general registers. Every arithmetic or logic operation is destructive: the first register is both a source and the destination. The two memory operations use the second register as the address.

Data memory is reached through a plain synchronous port. The port carries an address, write data and a write strobe, and read data comes back one cycle after the address is presented. The core has no branches, immediates or interrupts. It runs instructions in order until it meets an undefined operation code or an out-of-range shift amount. At that point it raises a sticky fault output, discards the offending result and stops until reset.

Top module: `dyad_core`

## Requirements
- R1: Instruction bits [5:0] are the operation code, bits [10:6] name the first register (Rn) and bits [15:11] name the second register (Rm). Codes: load=0x00, store=0x01, add=0x02, xor=0x03, shift-left=0x04, shift-right=0x05.
- R2: Add sets Rn to Rn + Rm, wrapping modulo 2^32 with no carry kept.
- R3: Xor sets Rn to the bitwise exclusive OR of Rn and Rm.
- R4: Shift-left sets Rn to Rn shifted left by the value of Rm, filling with zeros, for any value from 0 to 31.
- R5: Shift-right sets Rn to Rn shifted right logically by the value of Rm, for any value from 0 to 31.
- R6: In the single cycle a store executes, `dmem_we` is 1, `dmem_addr` equals Rm and `dmem_wdata` equals Rn. `dmem_we` is 0 in every other cycle.
- R7: A load presents Rm on `dmem_addr` with `dmem_we` low and holds the program counter. In the following cycle it writes `dmem_rdata` into Rn and advances the program counter, so a load takes two cycles.
- R8: A shift whose amount in Rm is 32 or larger is not retired. No register is written, the program counter stays on that instruction and `fault` is 1 from the next cycle on.
- R9: An operation code above 0x05 faults the same way, with no write and no store.
- R10: Once `fault` is 1 it stays 1, `ifetch_addr` stays frozen and `dmem_we` stays 0 until reset.
- R11: A synchronous active-high `rst` clears all registers and the program counter to zero and clears `fault`.
- R12: Add, xor, the shifts and store each take one cycle and advance the program counter by exactly one.
- R13: Instruction bits above bit 15, when the fetch word is wider, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ifetch_addr | output | PC_W | Program counter, one step per instruction word |
| ifetch_data | input | INSN_W | Instruction word at `ifetch_addr`, valid in the same cycle |
| dmem_addr | output | DATA_W | Data memory address (value of Rm) |
| dmem_wdata | output | DATA_W | Store data (value of Rn) |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | DATA_W | Read data, one cycle after the address |
| fault | output | 1 | Sticky fault, core halted |

## Verification
The bench builds the core with a 20-bit fetch word, an 8-bit program counter and the staged shifter variant. The wider fetch word lets it put noise in the unused top bits of every instruction. The staged shifter exercises the generate branch that the default build does not use. The short counter keeps the fetch memory small. Programs start from an all-zero register file and load their operands from preset memory. Stores expose the results, so the arithmetic corner cases can be seen at the ports: the add wrap, a shift by 31, and shift amounts of 32 and 255.

// File: rtl/dyad_pkg.sv
package dyad_pkg;
   localparam int OPC_W  = 6;
   localparam int FLD_W  = 5;
   localparam int RA_LSB = 6;
   localparam int RB_LSB = 11;
   localparam int ENC_W  = 16;
   localparam int NREG   = 1 << FLD_W;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 6'h00,
      OP_STORE = 6'h01,
      OP_ADD   = 6'h02,
      OP_XOR   = 6'h03,
      OP_SHL   = 6'h04,
      OP_SHR   = 6'h05
   } opc_e;

   localparam logic [OPC_W-1:0] OP_LAST = 6'h05;
endpackage

// File: rtl/dyad_decode.sv
module dyad_decode
   import dyad_pkg::*;
#(
   parameter int INSN_W = 16
) (
   input  logic [INSN_W-1:0] insn,
   output opc_e              op,
   output logic [FLD_W-1:0]  ra,
   output logic [FLD_W-1:0]  rb,
   output logic              legal,
   output logic              is_load,
   output logic              is_store,
   output logic              is_alu
);
   logic [OPC_W-1:0] raw;

   assign raw      = insn[OPC_W-1:0];
   assign op       = opc_e'(raw);
   assign ra       = insn[RA_LSB +: FLD_W];
   assign rb       = insn[RB_LSB +: FLD_W];
   assign legal    = (raw <= OP_LAST);
   assign is_load  = (raw == OP_LOAD);
   assign is_store = (raw == OP_STORE);
   assign is_alu   = legal && !is_load && !is_store;

   generate
      if (INSN_W > ENC_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^insn[INSN_W-1:ENC_W];
      end
   endgenerate
endmodule

// File: rtl/dyad_regfile.sv
module dyad_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] widx,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [$clog2(NREG)-1:0] ridx_a,
   input  logic [$clog2(NREG)-1:0] ridx_b,
   output logic [DATA_W-1:0]       rdata_a,
   output logic [DATA_W-1:0]       rdata_b
);
   localparam int IDX_W = $clog2(NREG);

   logic [DATA_W-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      for (int r = 0; r < NREG; r++) begin
         if (rst) begin
            regs[r] <= '0;
         end else if (we && widx == IDX_W'(r)) begin
            regs[r] <= wdata;
         end
      end
   end

   assign rdata_a = regs[ridx_a];
   assign rdata_b = regs[ridx_b];
endmodule

// File: rtl/dyad_alu.sv
module dyad_alu
   import dyad_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SHIFT_STYLE = 0
) (
   input  opc_e              op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y,
   output logic              amt_err
);
   localparam int SH_W = $clog2(DATA_W);

   logic              amt_big;
   logic [SH_W-1:0]   amt;
   logic [DATA_W-1:0] shl_y;
   logic [DATA_W-1:0] shr_y;

   assign amt     = b[SH_W-1:0];
   assign amt_big = |b[DATA_W-1:SH_W];
   assign amt_err = (op == OP_SHL || op == OP_SHR) && amt_big;

   generate
      if (SHIFT_STYLE == 0) begin : g_op_shift
         assign shl_y = a << amt;
         assign shr_y = a >> amt;
      end else begin : g_staged_shift
         logic [DATA_W-1:0] lst [SH_W+1];
         logic [DATA_W-1:0] rst_ [SH_W+1];
         assign lst[0]  = a;
         assign rst_[0] = a;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            assign lst[k+1]  = amt[k] ? (lst[k]  << (1 << k)) : lst[k];
            assign rst_[k+1] = amt[k] ? (rst_[k] >> (1 << k)) : rst_[k];
         end
         assign shl_y = lst[SH_W];
         assign shr_y = rst_[SH_W];
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_XOR:  y = a ^ b;
         OP_SHL:  y = shl_y;
         OP_SHR:  y = shr_y;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/dyad_core.sv
module dyad_core
   import dyad_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int PC_W        = 16,
   parameter int INSN_W      = 16,
   parameter int SHIFT_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [PC_W-1:0]   ifetch_addr,
   input  logic [INSN_W-1:0] ifetch_data,
   output logic [DATA_W-1:0] dmem_addr,
   output logic [DATA_W-1:0] dmem_wdata,
   output logic              dmem_we,
   input  logic [DATA_W-1:0] dmem_rdata,
   output logic              fault
);
   generate
      if (INSN_W < ENC_W) begin : g_chk_insn
         $error("INSN_W must hold the 16-bit encoding");
      end
      if ((DATA_W & (DATA_W - 1)) != 0 || DATA_W < 8) begin : g_chk_data
         $error("DATA_W must be a power of two, at least 8");
      end
      if (SHIFT_STYLE < 0 || SHIFT_STYLE > 1) begin : g_chk_style
         $error("SHIFT_STYLE selects 0 or 1");
      end
      if (PC_W < 1) begin : g_chk_pc
         $error("PC_W must be positive");
      end
   endgenerate

   opc_e              op;
   logic [FLD_W-1:0]  ra, rb;
   logic              legal, is_load, is_store, is_alu;
   logic [DATA_W-1:0] ra_val, rb_val, alu_y;
   logic              amt_err;

   logic [PC_W-1:0]   pc;
   logic              ld_wait;
   logic [FLD_W-1:0]  ld_dst;
   logic              halted;

   logic              run, bad, retire;
   logic              wr_en;
   logic [FLD_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;

   dyad_decode #(.INSN_W(INSN_W)) u_dec (
      .insn     (ifetch_data),
      .op       (op),
      .ra       (ra),
      .rb       (rb),
      .legal    (legal),
      .is_load  (is_load),
      .is_store (is_store),
      .is_alu   (is_alu)
   );

   dyad_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (wr_en),
      .widx    (wr_idx),
      .wdata   (wr_data),
      .ridx_a  (ra),
      .ridx_b  (rb),
      .rdata_a (ra_val),
      .rdata_b (rb_val)
   );

   dyad_alu #(.DATA_W(DATA_W), .SHIFT_STYLE(SHIFT_STYLE)) u_alu (
      .op      (op),
      .a       (ra_val),
      .b       (rb_val),
      .y       (alu_y),
      .amt_err (amt_err)
   );

   assign run    = !halted && !ld_wait;
   assign bad    = run && (!legal || amt_err);
   assign retire = (run && legal && !amt_err && !is_load) || ld_wait;

   assign wr_en   = (run && is_alu && !amt_err) || ld_wait;
   assign wr_idx  = ld_wait ? ld_dst : ra;
   assign wr_data = ld_wait ? dmem_rdata : alu_y;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc      <= '0;
         ld_wait <= 1'b0;
         ld_dst  <= '0;
         halted  <= 1'b0;
      end else begin
         if (retire) pc <= pc + 1'b1;
         ld_wait <= run && is_load;
         if (run && is_load) ld_dst <= ra;
         halted  <= halted || bad;
      end
   end

   assign ifetch_addr = pc;
   assign dmem_addr   = rb_val;
   assign dmem_wdata  = ra_val;
   assign dmem_we     = run && is_store;
   assign fault       = halted;
endmodule

// File: rtl/dyad_core_chk.sv
module dyad_core_chk #(
   parameter int PC_W   = 16,
   parameter int INSN_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [PC_W-1:0]   ifetch_addr,
   input logic [INSN_W-1:0] ifetch_data,
   input logic              dmem_we,
   input logic              fault,
   input logic              ld_wait
);
   logic       live;
   logic [5:0] opc;

   assign live = !fault && !ld_wait;
   assign opc  = ifetch_data[5:0];

   a_r10_fault_sticky: assert property (@(posedge clk) disable iff (rst)
      fault |=> fault);

   a_r10_halt_no_store: assert property (@(posedge clk) disable iff (rst)
      fault |-> !dmem_we);

   a_r10_pc_frozen: assert property (@(posedge clk) disable iff (rst)
      fault |=> $stable(ifetch_addr));

   a_r11_reset_state: assert property (@(posedge clk)
      rst |=> (ifetch_addr == '0 && !fault));

   a_r9_bad_code_faults: assert property (@(posedge clk) disable iff (rst)
      (live && opc > 6'h05) |=> fault);

   a_r7_load_stalls: assert property (@(posedge clk) disable iff (rst)
      (live && opc == 6'h00) |=> (ld_wait && $stable(ifetch_addr)));

   a_r6_store_strobe: assert property (@(posedge clk) disable iff (rst)
      (live && opc == 6'h01) |-> dmem_we);

   a_r12_add_steps: assert property (@(posedge clk) disable iff (rst)
      (live && (opc == 6'h02 || opc == 6'h03)) |=>
         (ifetch_addr == PC_W'($past(ifetch_addr) + 1'b1)));
endmodule

bind dyad_core dyad_core_chk #(.PC_W(PC_W), .INSN_W(INSN_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .ifetch_addr (ifetch_addr),
   .ifetch_data (ifetch_data),
   .dmem_we     (dmem_we),
   .fault       (fault),
   .ld_wait     (ld_wait)
);

// File: tb/dyad_core_tb.sv
`timescale 1ns/1ps
module dyad_core_tb;
   localparam int DW = 32;
   localparam int PW = 8;
   localparam int IW = 20;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [PW-1:0] ifetch_addr;
   logic [IW-1:0] ifetch_data;
   logic [DW-1:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic          dmem_we;
   logic          fault;

   logic [IW-1:0] imem [256];
   logic [31:0]   dmem [64];

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int ptr   = 0;

   always #2 clk = ~clk;

   dyad_core #(.DATA_W(DW), .PC_W(PW), .INSN_W(IW), .SHIFT_STYLE(1)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .ifetch_addr (ifetch_addr),
      .ifetch_data (ifetch_data),
      .dmem_addr   (dmem_addr),
      .dmem_wdata  (dmem_wdata),
      .dmem_we     (dmem_we),
      .dmem_rdata  (dmem_rdata),
      .fault       (fault)
   );

   assign ifetch_data = imem[ifetch_addr];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
      dmem_rdata <= dmem[dmem_addr[5:0]];
   end

   // reference model
   logic [31:0] mregs [32];
   logic [31:0] mmem  [64];
   int          mpc;
   bit          mwait, mfault, mvalid;
   logic [4:0]  mdst;
   logic [31:0] mld;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic [IW-1:0] w;
      logic [5:0]    op;
      logic [4:0]    a, b;
      w  = imem[mpc[PW-1:0]];
      op = w[5:0];
      a  = w[10:6];
      b  = w[15:11];
      if (mvalid && !rst) begin
         chk(ifetch_addr == mpc[PW-1:0], "R12 pc", 64'(ifetch_addr), 64'(mpc));
         chk(fault == mfault, "R10 fault", 64'(fault), 64'(mfault));
         chk(dmem_we == (!mfault && !mwait && op == 6'h01), "R6 strobe", 64'(dmem_we), 64'(!mfault && !mwait && op == 6'h01));
         if (!mfault && !mwait && op == 6'h01) begin
            chk(dmem_addr == mregs[b], "R6 addr", 64'(dmem_addr), 64'(mregs[b]));
            chk(dmem_wdata == mregs[a], "R6 data", 64'(dmem_wdata), 64'(mregs[a]));
         end
         if (!mfault && !mwait && op == 6'h00)
            chk(dmem_addr == mregs[b], "R7 addr", 64'(dmem_addr), 64'(mregs[b]));
      end
      if (rst) begin
         for (int i = 0; i < 32; i++) mregs[i] = '0;
         mpc = 0; mwait = 0; mfault = 0; mvalid = 1;
      end else if (mvalid && !mfault) begin
         if (mwait) begin
            mregs[mdst] = mld;
            mpc++;
            mwait = 0;
         end else begin
            case (op)
               6'h00: begin mld = mmem[mregs[b][5:0]]; mdst = a; mwait = 1; end
               6'h01: begin mmem[mregs[b][5:0]] = mregs[a]; mpc++; end
               6'h02: begin mregs[a] = mregs[a] + mregs[b]; mpc++; end
               6'h03: begin mregs[a] = mregs[a] ^ mregs[b]; mpc++; end
               6'h04: if (mregs[b] >= 32) mfault = 1;
                      else begin mregs[a] = mregs[a] << mregs[b]; mpc++; end
               6'h05: if (mregs[b] >= 32) mfault = 1;
                      else begin mregs[a] = mregs[a] >> mregs[b]; mpc++; end
               default: mfault = 1;
            endcase
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++; total++;
         $display("FAIL watchdog act=%0d exp=<20000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // upper bits carry noise (R13)
   task automatic put(input logic [5:0] op, input logic [4:0] a, input logic [4:0] b);
      imem[ptr] = {4'hA, b, a, op};
      ptr++;
   endtask

   task automatic poke(input int addr, input logic [31:0] v);
      dmem[addr] = v;
      mmem[addr] = v;
   endtask

   task automatic clear_all();
      for (int i = 0; i < 256; i++) imem[i] = '0;
      for (int i = 0; i < 64; i++) poke(i, 32'hDEAD0000 + 32'(i));
      ptr = 0;
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk); #0.5;
      chk(ifetch_addr == '0, "R11 pc after reset", 64'(ifetch_addr), 0);
      chk(fault == 1'b0, "R11 fault after reset", 64'(fault), 0);
   endtask

   task automatic run_to_fault();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (fault) break;
      end
      repeat (4) @(negedge clk);
      #0.5;
   endtask

   initial begin
      clear_all();
      // program A: arithmetic and boundary shifts
      poke(0, 1); poke(1, 2); poke(2, 32'hFFFF_FFFF);
      poke(3, 16); poke(4, 31); poke(5, 32'hFF);
      put(0, 1, 0);  put(0, 2, 1);  put(0, 3, 2);
      put(2, 4, 1);  put(2, 4, 2);  put(0, 10, 4); put(1, 4, 10);
      put(2, 5, 1);  put(3, 5, 2);  put(2, 10, 1); put(1, 5, 10);
      put(2, 7, 1);  put(4, 7, 2);  put(2, 10, 1); put(1, 7, 10);
      put(2, 8, 2);  put(5, 8, 1);  put(2, 10, 1); put(1, 8, 10);
      put(2, 9, 3);  put(2, 9, 2);  put(2, 10, 1); put(1, 9, 10);
      put(2, 12, 1); put(2, 14, 4); put(2, 14, 1); put(0, 13, 14);
      put(4, 12, 13); put(2, 10, 1); put(1, 12, 10);
      put(5, 12, 13); put(2, 10, 1); put(1, 12, 10);
      put(2, 14, 1); put(0, 15, 14); put(4, 1, 15);
      put(2, 10, 1); put(1, 1, 10);
      do_reset();
      run_to_fault();
      chk(dmem[16] == 32'd3, "R2 1+2", 64'(dmem[16]), 3);
      chk(dmem[17] == 32'd3, "R3 1^2", 64'(dmem[17]), 3);
      chk(dmem[18] == 32'd4, "R4 1<<2", 64'(dmem[18]), 4);
      chk(dmem[19] == 32'd1, "R5 2>>1", 64'(dmem[19]), 1);
      chk(dmem[20] == 32'd1, "R2 wrap", 64'(dmem[20]), 1);
      chk(dmem[21] == 32'h8000_0000, "R4 shift 31", 64'(dmem[21]), 64'h8000_0000);
      chk(dmem[22] == 32'd1, "R5 shift 31", 64'(dmem[22]), 1);
      chk(fault == 1'b1, "R8 shift 255 faults", 64'(fault), 1);
      chk(ifetch_addr == 8'd35, "R8 pc held", 64'(ifetch_addr), 35);
      chk(dmem[23] == 32'hDEAD0017, "R8 no later store", 64'(dmem[23]), 64'hDEAD0017);
      chk(dmem[0] == 32'd1, "R1 load source intact", 64'(dmem[0]), 1);

      // program B: reset clears registers, undefined code 0x3F
      @(posedge clk); #1;
      clear_all();
      poke(0, 32'h55);
      put(1, 4, 0); put(6'h3F, 1, 1); put(1, 0, 0);
      do_reset();
      run_to_fault();
      chk(dmem[0] == 32'd0, "R11 registers cleared", 64'(dmem[0]), 0);
      chk(fault == 1'b1, "R9 code 0x3F faults", 64'(fault), 1);
      chk(ifetch_addr == 8'd1, "R9 pc held", 64'(ifetch_addr), 1);
      repeat (10) @(negedge clk);
      #0.5;
      chk(fault == 1'b1 && ifetch_addr == 8'd1, "R10 halt holds", 64'({fault, ifetch_addr}), 64'({1'b1, 8'd1}));

      // program C: first undefined code 0x06
      @(posedge clk); #1;
      clear_all();
      put(6'h06, 0, 0); put(2, 0, 0);
      do_reset();
      run_to_fault();
      chk(fault == 1'b1 && ifetch_addr == 8'd0, "R9 code 0x06 faults", 64'({fault, ifetch_addr}), 64'({1'b1, 8'd0}));

      // program D: shift amount exactly 32
      @(posedge clk); #1;
      clear_all();
      poke(0, 6); poke(6, 32);
      put(0, 1, 0); put(0, 2, 1); put(5, 2, 2); put(1, 2, 0);
      do_reset();
      run_to_fault();
      chk(fault == 1'b1 && ifetch_addr == 8'd2, "R8 shift 32 faults", 64'({fault, ifetch_addr}), 64'({1'b1, 8'd2}));
      chk(dmem[0] == 32'd6, "R8 no store after fault", 64'(dmem[0]), 6);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule